// File: doc/BRIEF.md
# Duty-Cycled Power-State Sequencer

This controller runs one measurement pass of a battery-powered sensing node for every wake event it services. A wake request from the real-time clock, a pin or an analog threshold is latched, classified and given a sample-or-skip verdict while every gated domain is still dark. Only a pass that is allowed to proceed switches on the sensing rails. It then waits for the front end to settle, runs one bounded conversion burst and, once per programmed number of samples, asks a store stage to flush. Each pass ends with a fixed shutdown sequence and a return to sleep.

Every wait is cut short by a programmable limit, so the awake window always has a bound. A failure, whether a timeout or a fault flag, tears the domain down cleanly and retries after a backoff that doubles with each attempt, up to a programmed cap. An optional staged mode runs a cheap coarse check before any rail is powered. Sticky status bits record the causes seen, the limits that fired and an exhausted retry budget. Software clears each bit by writing 1 to it.

Top module: `pwr_cycle_seq`

## Requirements
- R1: After reset and in sleep, `core_on_o`, `rail_en_o`, `afe_run_o` and `flush_req_o` are 0 and `bus_rel_o` is 1. After reset, `status_o` and `retry_cnt_o` are 0.
- R2: A wake pulse is latched one clock after it is sampled, and the pass starts one clock later. If several causes are pending, the timer cause wins over the pin cause, and the pin cause wins over the threshold cause. Servicing a cause sets its sticky bit: bit 0 timer, bit 1 pin, bit 2 threshold.
- R3: A wake request that arrives while a pass is active stays pending. It is serviced after exactly one sleep cycle once the pass ends, and it is never lost.
- R4: The decision happens in the first awake cycle. A cause whose bit is set in `cfg_skip_i` (same bit order as R2) returns to sleep after that single cycle, and no rail is enabled.
- R5: `rail_en_o` rises only after at least one awake cycle with rails off. `afe_run_o` is high only while `rail_en_o` is high. With every handshake ready, a pass with a flush is 6 awake cycles long, 5 of them with rails on.
- R6: Teardown runs in a fixed order. `afe_run_o` is low first. `bus_rel_o` then rises while rails are still on. `rail_en_o` falls one cycle after that.
- R7: The settle, burst and flush waits each last at most `cfg_tmo_i`+1 cycles. A limit that expires sets status bit 3 (settle), bit 4 (burst) or bit 5 (flush). A done strobe that comes in the same cycle as the limit wins.
- R8: `fault_i` during any of the three waits is treated as a failure and sets status bit 6. It takes precedence over a done strobe.
- R9: After a failure the pass is retried while the retry count is below `cfg_retry_max_i`. Once the cap is reached, status bit 7 is set and the node goes to sleep. `retry_cnt_o` shows the retries used in the current pass.
- R10: Before retry k (counting from 1), rails stay off for `cfg_backoff_i << (k-1)` + 1 cycles, with `core_on_o` held high.
- R11: When `cfg_staged_i` is 1, a second awake cycle samples `coarse_hit_i` with rails off. If it is 0 the node returns to sleep. If it is 1 the pass proceeds to settling.
- R12: Completed samples are counted across passes. `flush_req_o` is raised only after the sample that brings the count to `cfg_batch_i`, and the count is cleared when a flush completes.
- R13: Status bits are sticky. Each bit clears when 1 is written to the same bit of `stat_clr_i`, and a new set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_rtc_i | input | 1 | Timer wake pulse |
| wake_gpio_i | input | 1 | Pin wake pulse |
| wake_thr_i | input | 1 | Threshold wake pulse |
| cfg_staged_i | input | 1 | Enable coarse pre-screen |
| cfg_skip_i | input | 3 | Per-cause skip mask |
| cfg_tmo_i | input | TMR_W | Wait limit in cycles |
| cfg_batch_i | input | BATCH_W | Samples per flush |
| cfg_retry_max_i | input | RETRY_W | Retry cap |
| cfg_backoff_i | input | TMR_W | Base backoff length |
| coarse_hit_i | input | 1 | Coarse screen flagged an event |
| settle_done_i | input | 1 | Front end settled |
| sample_done_i | input | 1 | Burst complete |
| store_done_i | input | 1 | Flush complete |
| fault_i | input | 1 | Failure flag |
| stat_clr_i | input | 8 | Write-1-to-clear status |
| core_on_o | output | 1 | Awake (core domain on) |
| rail_en_o | output | 1 | Gated sensing rails enable |
| afe_run_o | output | 1 | Converter and front-end run |
| bus_rel_o | output | 1 | Shared buses released |
| flush_req_o | output | 1 | Store stage request |
| status_o | output | 8 | Sticky status |
| retry_cnt_o | output | RETRY_W | Retries used in this pass |

## Verification
A wrong state register shows up at the ports within one clock, because every output is decoded from the registered state. A stuck or skipped state either breaks the strict rail, run and bus relations or changes the number of awake and powered cycles in a pass. The bench therefore counts awake cycles, powered cycles, flushes and rail rises per pass against figures derived from the limits and the backoff rule. A lost pending wake shows as a missing second pass. A wrong batch counter shows as a flush on the wrong sample.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int NCAUSE  = 3;
    localparam int CAUSE_W = 2;
    localparam int STAT_W  = 8;

    // cause indices, also their status bit positions; lower index wins
    localparam int CZ_RTC  = 0;
    localparam int CZ_GPIO = 1;
    localparam int CZ_THR  = 2;

    localparam int SB_TMO_WARM  = 3;
    localparam int SB_TMO_BURST = 4;
    localparam int SB_TMO_STORE = 5;
    localparam int SB_FAULT     = 6;
    localparam int SB_EXHAUST   = 7;

    typedef enum logic [3:0] {
        ST_SLEEP   = 4'd0,
        ST_WAKE    = 4'd1,
        ST_SCREEN  = 4'd2,
        ST_WARM    = 4'd3,
        ST_BURST   = 4'd4,
        ST_STORE   = 4'd5,
        ST_TD_STOP = 4'd6,
        ST_TD_REL  = 4'd7,
        ST_BACKOFF = 4'd8
    } pcs_state_e;
endpackage

// File: rtl/pcs_wake_latch.sv
module pcs_wake_latch #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          take_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    logic [N-1:0] pend_q, pend_d, take_mask;

    // lowest pending index is selected
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) idx_o = i[IW-1:0];
        end
    end

    always_comb begin
        take_mask = '0;
        if (take_i) take_mask[idx_o] = 1'b1;
        pend_d = (pend_q & ~take_mask) | req_i;
    end

    assign any_o = |pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/pcs_timer.sv
module pcs_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d;

    always_comb begin
        if (clr_i)          cnt_d = '0;
        else if (&cnt_o)    cnt_d = cnt_o;
        else                cnt_d = cnt_o + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_o <= '0;
        else        cnt_o <= cnt_d;
    end
endmodule

// File: rtl/pcs_sticky.sv
module pcs_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_d;

    assign q_d = (q_o & ~clr_i) | set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= q_d;
    end
endmodule

// File: rtl/pwr_cycle_seq.sv
module pwr_cycle_seq
    import pcs_pkg::*;
#(
    parameter int TMR_W   = 16,
    parameter int BATCH_W = 8,
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_rtc_i,
    input  logic               wake_gpio_i,
    input  logic               wake_thr_i,
    input  logic               cfg_staged_i,
    input  logic [NCAUSE-1:0]  cfg_skip_i,
    input  logic [TMR_W-1:0]   cfg_tmo_i,
    input  logic [BATCH_W-1:0] cfg_batch_i,
    input  logic [RETRY_W-1:0] cfg_retry_max_i,
    input  logic [TMR_W-1:0]   cfg_backoff_i,
    input  logic               coarse_hit_i,
    input  logic               settle_done_i,
    input  logic               sample_done_i,
    input  logic               store_done_i,
    input  logic               fault_i,
    input  logic [STAT_W-1:0]  stat_clr_i,
    output logic               core_on_o,
    output logic               rail_en_o,
    output logic               afe_run_o,
    output logic               bus_rel_o,
    output logic               flush_req_o,
    output logic [STAT_W-1:0]  status_o,
    output logic [RETRY_W-1:0] retry_cnt_o
);
    typedef struct packed {
        pcs_state_e           st;
        logic [CAUSE_W-1:0]   cause;
        logic [BATCH_W-1:0]   batch;
        logic [RETRY_W-1:0]   retry;
        logic                 retry_go;
    } seq_t;

    seq_t r_q, r_d;

    logic [NCAUSE-1:0]  wake_req;
    logic               wake_any;
    logic [CAUSE_W-1:0] wake_idx;
    logic               take;
    logic [STAT_W-1:0]  st_set;
    logic [TMR_W-1:0]   tmr_q;
    logic               tmr_clr;
    logic               tmo_hit;
    logic               fail;
    logic [TMR_W-1:0]   bo_len;
    logic [BATCH_W-1:0] batch_inc;

    assign wake_req = {wake_thr_i, wake_gpio_i, wake_rtc_i};

    pcs_wake_latch #(.N(NCAUSE), .IW(CAUSE_W)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (wake_req),
        .take_i (take),
        .any_o  (wake_any),
        .idx_o  (wake_idx)
    );

    // state-age counter, restarts on every transition
    assign tmr_clr = (r_d.st != r_q.st);

    pcs_timer #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (tmr_q)
    );

    pcs_sticky #(.W(STAT_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (st_set),
        .clr_i (stat_clr_i),
        .q_o   (status_o)
    );

    assign tmo_hit   = (tmr_q >= cfg_tmo_i);
    assign bo_len    = cfg_backoff_i << (r_q.retry - 1'b1);
    assign batch_inc = r_q.batch + 1'b1;

    always_comb begin
        r_d    = r_q;
        take   = 1'b0;
        st_set = '0;
        fail   = 1'b0;
        unique case (r_q.st)
            ST_SLEEP: begin
                if (wake_any) begin
                    take             = 1'b1;
                    r_d.cause        = wake_idx;
                    st_set[wake_idx] = 1'b1;
                    r_d.st           = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (cfg_skip_i[r_q.cause]) r_d.st = ST_SLEEP;
                else if (cfg_staged_i)     r_d.st = ST_SCREEN;
                else                       r_d.st = ST_WARM;
            end
            ST_SCREEN: begin
                r_d.st = coarse_hit_i ? ST_WARM : ST_SLEEP;
            end
            ST_WARM: begin
                if (fault_i) begin
                    fail = 1'b1;
                    st_set[SB_FAULT] = 1'b1;
                end else if (settle_done_i) begin
                    r_d.st = ST_BURST;
                end else if (tmo_hit) begin
                    fail = 1'b1;
                    st_set[SB_TMO_WARM] = 1'b1;
                end
            end
            ST_BURST: begin
                if (fault_i) begin
                    fail = 1'b1;
                    st_set[SB_FAULT] = 1'b1;
                end else if (sample_done_i) begin
                    r_d.batch = batch_inc;
                    r_d.st    = (batch_inc >= cfg_batch_i) ? ST_STORE : ST_TD_STOP;
                end else if (tmo_hit) begin
                    fail = 1'b1;
                    st_set[SB_TMO_BURST] = 1'b1;
                end
            end
            ST_STORE: begin
                if (fault_i) begin
                    fail = 1'b1;
                    st_set[SB_FAULT] = 1'b1;
                end else if (store_done_i) begin
                    r_d.batch = '0;
                    r_d.st    = ST_TD_STOP;
                end else if (tmo_hit) begin
                    fail = 1'b1;
                    st_set[SB_TMO_STORE] = 1'b1;
                end
            end
            ST_TD_STOP: r_d.st = ST_TD_REL;
            ST_TD_REL: begin
                if (r_q.retry_go) begin
                    r_d.st       = ST_BACKOFF;
                    r_d.retry_go = 1'b0;
                end else begin
                    r_d.st    = ST_SLEEP;
                    r_d.retry = '0;
                end
            end
            ST_BACKOFF: begin
                if (tmr_q >= bo_len) r_d.st = ST_WARM;
            end
            default: r_d.st = ST_SLEEP;
        endcase

        if (fail) begin
            r_d.st = ST_TD_STOP;
            if (r_q.retry < cfg_retry_max_i) begin
                r_d.retry    = r_q.retry + 1'b1;
                r_d.retry_go = 1'b1;
            end else begin
                r_d.retry_go       = 1'b0;
                st_set[SB_EXHAUST] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign core_on_o   = (r_q.st != ST_SLEEP);
    assign rail_en_o   = r_q.st inside {ST_WARM, ST_BURST, ST_STORE, ST_TD_STOP, ST_TD_REL};
    assign afe_run_o   = (r_q.st == ST_BURST);
    assign bus_rel_o   = !(r_q.st inside {ST_WARM, ST_BURST, ST_STORE, ST_TD_STOP});
    assign flush_req_o = (r_q.st == ST_STORE);
    assign retry_cnt_o = r_q.retry;
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk
    import pcs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              core_on,
    input logic              rail,
    input logic              run,
    input logic              bus_rel,
    input logic              flush,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] stat_clr
);
    AST_SLEEP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !core_on |-> (!rail && !run && !flush && bus_rel)); // R1

    AST_RUN_NEEDS_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> rail); // R5

    AST_RAIL_AFTER_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail) |-> $past(core_on)); // R5

    AST_BUS_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rel) |-> (rail && $past(!run))); // R6

    AST_RAIL_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail) |-> ($past(bus_rel) && !run)); // R6

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ($past(status) & ~$past(stat_clr))) == ($past(status) & ~$past(stat_clr)))); // R13
endmodule

bind pwr_cycle_seq pcs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_on  (core_on_o),
    .rail     (rail_en_o),
    .run      (afe_run_o),
    .bus_rel  (bus_rel_o),
    .flush    (flush_req_o),
    .status   (status_o),
    .stat_clr (stat_clr_i)
);

// File: tb/tb_pwr_cycle_seq.sv
`timescale 1ns/1ps
module tb_pwr_cycle_seq;
    localparam int TMR_W = 16, BATCH_W = 8, RETRY_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake_rtc = 0, wake_gpio = 0, wake_thr = 0;
    logic cfg_staged = 0;
    logic [2:0] cfg_skip = '0;
    logic [TMR_W-1:0] cfg_tmo = 16'd4;
    logic [BATCH_W-1:0] cfg_batch = 8'd1;
    logic [RETRY_W-1:0] cfg_retry_max = '0;
    logic [TMR_W-1:0] cfg_backoff = 16'd1;
    logic coarse_hit = 0, settle_done = 1, sample_done = 1, store_done = 1, fault = 0;
    logic [7:0] stat_clr = '0;
    logic core_on, rail_en, afe_run, bus_rel, flush_req;
    logic [7:0] status;
    logic [RETRY_W-1:0] retry_cnt;

    int n_chk = 0, n_fail = 0;
    bit mon_batch = 0;
    int bcnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwr_cycle_seq #(.TMR_W(TMR_W), .BATCH_W(BATCH_W), .RETRY_W(RETRY_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .wake_rtc_i(wake_rtc), .wake_gpio_i(wake_gpio), .wake_thr_i(wake_thr),
        .cfg_staged_i(cfg_staged), .cfg_skip_i(cfg_skip), .cfg_tmo_i(cfg_tmo),
        .cfg_batch_i(cfg_batch), .cfg_retry_max_i(cfg_retry_max), .cfg_backoff_i(cfg_backoff),
        .coarse_hit_i(coarse_hit), .settle_done_i(settle_done), .sample_done_i(sample_done),
        .store_done_i(store_done), .fault_i(fault), .stat_clr_i(stat_clr),
        .core_on_o(core_on), .rail_en_o(rail_en), .afe_run_o(afe_run), .bus_rel_o(bus_rel),
        .flush_req_o(flush_req), .status_o(status), .retry_cnt_o(retry_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input bit r, input bit g, input bit t);
        wake_rtc = r; wake_gpio = g; wake_thr = t;
        step();
        wake_rtc = 0; wake_gpio = 0; wake_thr = 0;
    endtask

    task automatic clear_status();
        stat_clr = 8'hFF; step(); stat_clr = 8'h00;
    endtask

    // follow one pass until the node is back in sleep
    task automatic observe(output int awake, output int rail_c, output int flush_c,
                           output int rises, output int maxr);
        bit started = 0;
        bit pr = 0;
        awake = 0; rail_c = 0; flush_c = 0; rises = 0; maxr = 0;
        for (int i = 0; i < 2000; i++) begin
            step();
            if (core_on) begin
                started = 1;
                awake++;
                rail_c  += int'(rail_en);
                flush_c += int'(flush_req);
                if (rail_en && !pr) rises++;
                if (int'(retry_cnt) > maxr) maxr = int'(retry_cnt);
            end else if (started) begin
                break;
            end
            pr = rail_en;
        end
    endtask

    // inputs as seen at the last rising edge
    logic e_sample, e_store, e_fault;
    always @(posedge clk) begin
        e_sample <= sample_done;
        e_store  <= store_done;
        e_fault  <= fault;
    end

    // per-cycle port relations
    logic p_core, p_rail, p_run, p_bus, pp_bus, p_flush;
    always @(negedge clk) begin
        if (!rst_n) begin
            p_core = 0; p_rail = 0; p_run = 0; p_bus = 1; pp_bus = 1; p_flush = 0;
        end else begin
            if (!core_on)
                chk(!rail_en && !afe_run && bus_rel && !flush_req, "R1 sleep outputs",
                    {rail_en, afe_run, bus_rel, flush_req}, 2);
            if (afe_run) chk(rail_en, "R5 run without rail", rail_en, 1);
            if (rail_en && !p_rail) chk(p_core, "R5 rail before decision", p_core, 1);
            if (bus_rel && !p_bus) chk(!p_run && rail_en, "R6 bus release order",
                                        {p_run, rail_en}, 1);
            if (!rail_en && p_rail) chk(p_bus && !p_run && !pp_bus, "R6 rail off order",
                                         {p_bus, p_run, pp_bus}, 4);
            if (mon_batch) begin
                if (p_run && e_sample && !e_fault) begin
                    bcnt++;
                    chk(flush_req == (bcnt >= int'(cfg_batch)), "R12 flush on batch",
                        flush_req, bcnt >= int'(cfg_batch));
                end
                if (p_flush && e_store && !e_fault) bcnt = 0;
            end
            pp_bus = p_bus; p_bus = bus_rel; p_core = core_on;
            p_rail = rail_en; p_run = afe_run; p_flush = flush_req;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int aw, rc, fc, rs, mr;
        void'($urandom(32'd20240611));
        repeat (3) step();
        // R1: reset state
        chk(!core_on && !rail_en && !afe_run && bus_rel && !flush_req, "R1 reset outputs",
            {core_on, rail_en, afe_run, bus_rel, flush_req}, 2);
        chk(status == 0 && retry_cnt == 0, "R1 reset status", status, 0);
        rst_n = 1'b1;
        repeat (2) step();

        // R5: plain pass, batch of one
        pulse(1, 0, 0);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 6, "R5 awake cycles", aw, 6);
        chk(rc == 5, "R5 powered cycles", rc, 5);
        chk(fc == 1, "R12 flush with batch 1", fc, 1);
        chk(status == 8'h01, "R2 timer cause bit", status, 1);

        // R4: skipped cause
        cfg_skip = 3'b001;
        pulse(1, 0, 0);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 1, "R4 skip awake", aw, 1);
        chk(rc == 0, "R4 skip no rail", rc, 0);
        cfg_skip = 3'b000;

        // R11: staged screen
        cfg_staged = 1; coarse_hit = 0;
        pulse(0, 1, 0);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 2 && rc == 0, "R11 screen miss", aw, 2);
        coarse_hit = 1;
        pulse(0, 1, 0);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 7 && rc == 5, "R11 screen hit", aw, 7);
        cfg_staged = 0; coarse_hit = 0;

        // R2: priority, threshold skipped
        clear_status();
        cfg_skip = 3'b100;
        pulse(1, 0, 1);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 6 && rc == 5, "R2 timer served first", aw, 6);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 1 && rc == 0, "R2 threshold served second", aw, 1);
        chk(status == 8'h05, "R2 cause bits", status, 5);
        cfg_skip = 3'b000;

        // R13: write one to clear
        stat_clr = 8'h01; step(); stat_clr = 8'h00;
        chk(status == 8'h04, "R13 clear one bit", status, 4);
        clear_status();

        // R3: wake during an active pass
        pulse(1, 0, 0);
        step(); step();
        pulse(0, 1, 0);
        observe(aw, rc, fc, rs, mr);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 6, "R3 pending wake served", aw, 6);
        chk(status[1] == 1'b1, "R3 pin cause recorded", status[1], 1);
        clear_status();

        // R7: settle limit
        settle_done = 0;
        pulse(1, 0, 0);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 8 && rc == 7, "R7 settle limit length", aw, 8);
        chk(status == 8'h89, "R7 settle limit status", status, 8'h89);
        settle_done = 1; clear_status();
        // R7: burst limit
        sample_done = 0;
        pulse(1, 0, 0);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 9, "R7 burst limit length", aw, 9);
        chk(status == 8'h91, "R7 burst limit status", status, 8'h91);
        sample_done = 1; clear_status();
        // R7: flush limit
        store_done = 0;
        pulse(1, 0, 0);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 10 && fc == 5, "R7 flush limit length", aw, 10);
        chk(status == 8'hA1, "R7 flush limit status", status, 8'hA1);
        store_done = 1; clear_status();
        pulse(1, 0, 0);
        observe(aw, rc, fc, rs, mr);
        clear_status();

        // R8: fault beats settle done
        fault = 1;
        pulse(1, 0, 0);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 4 && rc == 3, "R8 fault pass length", aw, 4);
        chk(status == 8'hC1, "R8 fault status", status, 8'hC1);
        fault = 0; clear_status();

        // R9/R10: two retries with doubling backoff
        settle_done = 0; cfg_tmo = 16'd2; cfg_retry_max = 4'd2; cfg_backoff = 16'd3;
        pulse(1, 0, 0);
        observe(aw, rc, fc, rs, mr);
        chk(aw == 27, "R10 awake with backoff", aw, 27);
        chk(rc == 15, "R10 powered cycles", rc, 15);
        chk(rs == 3, "R9 attempts", rs, 3);
        chk(mr == 2, "R9 retry count", mr, 2);
        chk(status == 8'h89 && retry_cnt == 0, "R9 exhausted", status, 8'h89);
        settle_done = 1; cfg_tmo = 16'd4; cfg_retry_max = 0; cfg_backoff = 16'd1;
        clear_status();

        // R12: batch of three
        cfg_batch = 8'd3;
        for (int k = 1; k <= 3; k++) begin
            pulse(0, 0, 1);
            observe(aw, rc, fc, rs, mr);
            chk(fc == (k == 3 ? 1 : 0), "R12 batch flush", fc, k == 3);
            chk(aw == (k == 3 ? 6 : 5), "R12 batch pass length", aw, k == 3 ? 6 : 5);
        end

        // constrained random phase from a fresh reset
        rst_n = 0; step(); rst_n = 1; step();
        cfg_batch = 8'd2; cfg_tmo = 16'd6; cfg_retry_max = 4'd1; cfg_backoff = 16'd2;
        cfg_staged = 1; cfg_skip = 3'b100;
        bcnt = 0; mon_batch = 1;
        for (int c = 0; c < 4000; c++) begin
            wake_rtc    = ($urandom % 24) == 0;
            wake_gpio   = ($urandom % 24) == 0;
            wake_thr    = ($urandom % 24) == 0;
            coarse_hit  = ($urandom % 2) == 0;
            settle_done = ($urandom % 3) == 0;
            sample_done = ($urandom % 3) == 0;
            store_done  = ($urandom % 3) == 0;
            fault       = ($urandom % 64) == 0;
            stat_clr    = (($urandom % 16) == 0) ? 8'($urandom) : 8'h00;
            step();
        end
        mon_batch = 0;
        wake_rtc = 0; wake_gpio = 0; wake_thr = 0; fault = 0; stat_clr = 0;
        settle_done = 1; sample_done = 1; store_done = 1;
        repeat (200) step();
        chk(!core_on, "R1 idle after random", core_on, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule